// File: doc/BRIEF.md
# Per-Port Interrupt Status Controller

This block gathers 32 interrupt sources of one link port into a single status word and drives one interrupt line towards the system interrupt controller. The four lowest sources are legacy level-sensitive lines. Their status bits follow the input pins directly, and software cannot clear them. All higher sources are edge-triggered. A rising edge sets a sticky status bit, and the bit stays set until software writes a one to it. Named source positions include link-up (12), link-down (14), a request-ID mapping error (22), completion timeout (23) and a tunnel fault (31). Bits 4 to 7 carry the error-reporting sources.

Software masks sources through a mask word. It never writes that word directly. A write to a set address ORs ones into the mask, and a write to a clear address removes ones from it, so one source can be enabled or disabled without a read-modify-write. The interrupt output is registered and is high when any unmasked status bit is set.

The CPU side is a single-cycle request interface: valid, write, word address and write data. Read data comes back one cycle after the request, together with a read-valid flag.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every edge status bit is 0, the interrupt output is low and read-valid is low.
- R2: Status bits 0 to 3 read back the current level of source inputs 0 to 3, with no latching.
- R3: A write of ones to status bits 0 to 3 at the status address (word address 0) changes nothing that software can read.
- R4: A rising edge on a source 4 to 31 sets its status bit. The bit stays set after the source falls.
- R5: A write to the status address clears each edge status bit whose data bit is 1. Bits written as 0 are unchanged.
- R6: When a rising edge of a source and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R7: A write to the mask-set address (word address 2) sets the mask bits whose data bits are 1 and leaves the other mask bits unchanged.
- R8: A write to the mask-clear address (word address 3) clears the mask bits whose data bits are 1 and leaves the other mask bits unchanged.
- R9: The interrupt output is the OR over all bits of status AND NOT mask, delayed by one register stage.
- R10: A read at word address 0 returns status and a read at word address 1 returns the mask. Both arrive one cycle after the request, with read-valid high. A read of address 2 or 3 returns 0, and a write to address 1 leaves the mask unchanged.
- R11: The interrupt from an unmasked level source drops one register stage after the source input falls, with no software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs; bits 0-3 level, the rest edge |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 status, 1 mask, 2 mask-set, 3 mask-clear |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the read request |
| bus_rvalid_o | output | 1 | High in the cycle the read data is presented |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench drives a source edge and a clearing write to the same bit in the same cycle. A design that gave the clear priority would lose that event and read back 0. It writes ones to the level bits and checks they still follow their pins, which catches a design that latches or clears them. Mask-set and mask-clear writes carry a single data bit each time, and the bench reads back the whole mask. A design that loads the data word directly, or treats zero bits as clears, shows up as a wrong mask word. The bench samples the interrupt output both one cycle and two cycles after a mask or status change. This catches a missing or an extra register stage on the output.

// File: rtl/irq_stat_pkg.sv
// Package: shared register selects, write strobe bundle and named source
// positions for the per-port interrupt status controller.
package irq_stat_pkg;

    // Word address width of the register window.
    localparam int unsigned REG_ADDR_W = 2;

    // Register selects; the numeric codes are the software-visible addresses.
    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_STATUS   = 2'd0,
        SEL_MASK     = 2'd1,
        SEL_MASK_SET = 2'd2,
        SEL_MASK_CLR = 2'd3
    } reg_sel_e;

    // Decoded write strobes, one per writable function.
    typedef struct packed {
        logic status_w1c;
        logic mask_set;
        logic mask_clr;
    } wr_strobe_t;

    // Source positions with a fixed meaning inside the status word.
    localparam int unsigned SRC_ERR_FIRST  = 4;
    localparam int unsigned SRC_ERR_LAST   = 7;
    localparam int unsigned SRC_LINK_UP    = 12;
    localparam int unsigned SRC_LINK_DOWN  = 14;
    localparam int unsigned SRC_MAP_ERR    = 22;
    localparam int unsigned SRC_CPL_TMO    = 23;
    localparam int unsigned SRC_TUNNEL_ERR = 31;

endpackage

// File: rtl/irq_edge_detect.sv
// Module: irq_edge_detect
// Produces a one-cycle rise pulse for every source that is high now and was
// low in the previous cycle.
// Assumes: sources are already synchronous to clk. The history register
// resets to 0, so a source that is high when reset is released counts as a
// rising edge in the first cycle.
module irq_edge_detect #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] rise_o
);

    logic [NUM_SRC-1:0] prev_q;

    // Remember last cycle's source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= src_i;
        end
    end

    // Rise = high now, low before.
    always_comb begin
        rise_o = src_i & ~prev_q;
    end

    // A rise pulse never lasts two cycles in a row on the same bit.
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R4

endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Holds the status word. The lowest NUM_LEVEL bits pass the source levels
// straight through. The remaining bits are sticky flags that a rise pulse
// sets and a write-one clear resets, and the rise wins when both arrive in
// the same cycle.
// Assumes: clr_en_i is a single-cycle strobe, and clear data bits for level
// positions are ignored.
module irq_status_bank #(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_LEVEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_data_i,
    output logic [NUM_SRC-1:0] status_o
);

    localparam logic [NUM_SRC-1:0] ALL_ONES  = {NUM_SRC{1'b1}};
    localparam logic [NUM_SRC-1:0] EDGE_MASK = ALL_ONES << NUM_LEVEL;

    logic [NUM_SRC-1:0] edge_q;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] rise_edge;

    // Qualify clear data and rise pulses to the edge-triggered positions.
    always_comb begin
        clr_vec   = clr_en_i ? (clr_data_i & EDGE_MASK) : '0;
        rise_edge = rise_i & EDGE_MASK;
    end

    // Sticky flags: clear first, then OR in new edges so a same-cycle edge survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= (edge_q & ~clr_vec) | rise_edge;
        end
    end

    // Pick the live level or the sticky flag for each bit.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (i < NUM_LEVEL) begin : g_level
            assign status_o[i] = src_i[i];
        end else begin : g_edge
            assign status_o[i] = edge_q[i];
        end
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_edge != '0) |=> ((edge_q & $past(rise_edge)) == $past(rise_edge))); // R6

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en_i |=> ((edge_q & $past(edge_q)) == $past(edge_q))); // R4

    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((edge_q & $past(clr_data_i & ~rise_i & EDGE_MASK)) == '0)); // R5

endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// Holds the mask word. It is changed only through a set strobe, which ORs
// data ones in, and a clear strobe, which removes data ones. It resets to
// all ones.
// Assumes: at most one of the two strobes is high in a cycle, which the
// address decode guarantees.
module irq_mask_bank #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] data_i,
    output logic [NUM_SRC-1:0] mask_o
);

    logic [NUM_SRC-1:0] mask_q;

    // Atomic set/clear update; all sources masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (set_en_i) begin
            mask_q <= mask_q | data_i;
        end else if (clr_en_i) begin
            mask_q <= mask_q & ~data_i;
        end
    end

    assign mask_o = mask_q;

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((mask_q & $past(data_i)) == $past(data_i))); // R7

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((mask_q & $past(data_i)) == '0)); // R8

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en_i || clr_en_i) |=> ((mask_q ^ $past(mask_q)) == (($past(mask_q) ^ mask_q) & $past(data_i)))); // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(mask_q)); // R10

endmodule

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Decodes single-cycle bus requests into write strobes and returns
// registered read data one cycle after a read request.
// Assumes: a request is valid for exactly one cycle. Writes to the mask
// address and reads of the set or clear addresses have no register behind
// them.
module irq_reg_decode
    import irq_stat_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  write_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [NUM_SRC-1:0]    status_i,
    input  logic [NUM_SRC-1:0]    mask_i,
    output wr_strobe_t            wr_o,
    output logic [NUM_SRC-1:0]    rdata_o,
    output logic                  rvalid_o
);

    reg_sel_e           sel;
    logic               rd_en;
    logic [NUM_SRC-1:0] rd_mux;

    // Combinational decode of address and direction.
    always_comb begin
        sel           = reg_sel_e'(addr_i);
        rd_en         = valid_i && !write_i;
        wr_o          = '0;
        wr_o.status_w1c = valid_i && write_i && (sel == SEL_STATUS);
        wr_o.mask_set   = valid_i && write_i && (sel == SEL_MASK_SET);
        wr_o.mask_clr   = valid_i && write_i && (sel == SEL_MASK_CLR);
        case (sel)
            SEL_STATUS: rd_mux = status_i;
            SEL_MASK:   rd_mux = mask_i;
            default:    rd_mux = '0;
        endcase
    end

    // Register the read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en;
            if (rd_en) begin
                rdata_o <= rd_mux;
            end
        end
    end

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid_o); // R10

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_o.status_w1c, wr_o.mask_set, wr_o.mask_clr})); // R10

endmodule

// File: rtl/irq_stat_ctrl.sv
// Module: irq_stat_ctrl
// Per-port interrupt status controller. It combines edge detection, the
// status word, the mask word and the register decode, and registers one
// interrupt output equal to the OR of the unmasked status bits.
// Assumes: source inputs are synchronous to clk, and bus requests last one
// cycle each.
module irq_stat_ctrl
    import irq_stat_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter int unsigned NUM_LEVEL = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [NUM_SRC-1:0]    bus_wdata_i,
    output logic [NUM_SRC-1:0]    bus_rdata_o,
    output logic                  bus_rvalid_o,
    output logic                  irq_o
);

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    wr_strobe_t         wr;
    logic               irq_q;

    irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC), .NUM_LEVEL(NUM_LEVEL)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .rise_i     (rise),
        .clr_en_i   (wr.status_w1c),
        .clr_data_i (bus_wdata_i),
        .status_o   (status)
    );

    irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (wr.mask_set),
        .clr_en_i (wr.mask_clr),
        .data_i   (bus_wdata_i),
        .mask_o   (mask)
    );

    irq_reg_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (bus_valid_i),
        .write_i  (bus_write_i),
        .addr_i   (bus_addr_i),
        .status_i (status),
        .mask_i   (mask),
        .wr_o     (wr),
        .rdata_o  (bus_rdata_o),
        .rvalid_o (bus_rvalid_o)
    );

    // Register the OR of unmasked pending bits onto the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & ~mask);
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |=> !irq_o); // R9

    AST_IRQ_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq_o); // R11

endmodule

// File: tb/irq_stat_ctrl_test.sv
module irq_stat_ctrl_test;

    localparam int unsigned N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          bvalid = 1'b0;
    logic          bwrite = 1'b0;
    logic [1:0]    baddr = '0;
    logic [N-1:0]  bwdata = '0;
    logic [N-1:0]  brdata;
    logic          brvalid;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    irq_stat_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src),
        .bus_valid_i  (bvalid),
        .bus_write_i  (bwrite),
        .bus_addr_i   (baddr),
        .bus_wdata_i  (bwdata),
        .bus_rdata_o  (brdata),
        .bus_rvalid_o (brvalid),
        .irq_o        (irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bvalid = 1'b1; bwrite = 1'b1; baddr = a; bwdata = d;
        @(negedge clk);
        bvalid = 1'b0; bwrite = 1'b0; bwdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bvalid = 1'b1; bwrite = 1'b0; baddr = a;
        @(negedge clk);
        bvalid = 1'b0;
        check(brvalid === 1'b1, "R10 rvalid", {31'd0, brvalid}, 32'd1);
        d = brdata;
    endtask

    task automatic pulse(input int b);
        @(negedge clk); src[b] = 1'b1;
        @(negedge clk); src[b] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq === 1'b0, "R1 irq low", {31'd0, irq}, 32'd0);
        check(brvalid === 1'b0, "R1 rvalid low", {31'd0, brvalid}, 32'd0);
        rd(2'd0, d); check(d === 32'h0, "R1 status", d, 32'h0);
        rd(2'd1, d); check(d === 32'hFFFF_FFFF, "R1 mask", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src[3:0] = 4'b1010;
        rd(2'd0, d); check(d === 32'hA, "R2 level live", d, 32'hA);
        wr(2'd0, 32'hF);
        rd(2'd0, d); check(d === 32'hA, "R3 level w1c ignored", d, 32'hA);
        @(negedge clk); src[3:0] = 4'b0101;
        rd(2'd0, d); check(d === 32'h5, "R2 level follows", d, 32'h5);
        @(negedge clk); src[3:0] = 4'b0000;
        rd(2'd0, d); check(d === 32'h0, "R2 level low", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        pulse(12);
        pulse(14);
        rd(2'd0, d); check(d === 32'h0000_5000, "R4 edge latched", d, 32'h0000_5000);
        repeat (3) @(negedge clk);
        rd(2'd0, d); check(d === 32'h0000_5000, "R4 sticky", d, 32'h0000_5000);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(2'd0, 32'h0000_1000);
        rd(2'd0, d); check(d === 32'h0000_4000, "R5 clear one bit", d, 32'h0000_4000);
        wr(2'd0, 32'h0);
        rd(2'd0, d); check(d === 32'h0000_4000, "R5 zero write keeps", d, 32'h0000_4000);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        @(negedge clk);
        src[23] = 1'b1;
        bvalid = 1'b1; bwrite = 1'b1; baddr = 2'd0; bwdata = 32'h0080_0000;
        @(negedge clk);
        src[23] = 1'b0;
        bvalid = 1'b0; bwrite = 1'b0; bwdata = '0;
        rd(2'd0, d); check(d === 32'h0080_4000, "R6 edge beats clear", d, 32'h0080_4000);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(2'd3, 32'h0000_1000);
        rd(2'd1, d); check(d === 32'hFFFF_EFFF, "R8 mask clear", d, 32'hFFFF_EFFF);
        wr(2'd3, 32'h0);
        rd(2'd1, d); check(d === 32'hFFFF_EFFF, "R8 zero clear keeps", d, 32'hFFFF_EFFF);
        wr(2'd3, 32'h0000_0F00);
        wr(2'd2, 32'h0000_1000);
        rd(2'd1, d); check(d === 32'hFFFF_F0FF, "R7 mask set", d, 32'hFFFF_F0FF);
        wr(2'd2, 32'h0);
        rd(2'd1, d); check(d === 32'hFFFF_F0FF, "R7 zero set keeps", d, 32'hFFFF_F0FF);
        wr(2'd2, 32'h0000_0F00);
        wr(2'd1, 32'h0);
        rd(2'd1, d); check(d === 32'hFFFF_FFFF, "R10 mask addr write ignored", d, 32'hFFFF_FFFF);
        rd(2'd2, d); check(d === 32'h0, "R10 set addr reads zero", d, 32'h0);
        rd(2'd3, d); check(d === 32'h0, "R10 clear addr reads zero", d, 32'h0);
    endtask

    task automatic t_irq();
        check(irq === 1'b0, "R9 masked quiet", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'h0000_4000);
        check(irq === 1'b0, "R9 one stage delay", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check(irq === 1'b1, "R9 unmasked pending", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0000_4000);
        check(irq === 1'b1, "R9 clear delay", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check(irq === 1'b0, "R9 cleared quiet", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'h0000_0002);
        @(negedge clk); src[1] = 1'b1;
        @(negedge clk);
        check(irq === 1'b1, "R11 level raises irq", {31'd0, irq}, 32'd1);
        src[1] = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R11 level drop clears irq", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_w1c();
        t_collide();
        t_mask();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule